// File: doc/BRIEF.md
# Branch and Jump Resolution Unit

This unit sits beside the execute stage of a 64-bit RISC core and decides, for one instruction per cycle, whether control flow leaves the sequential path and where it goes. It receives the 32-bit program counter of the instruction, the 32-bit instruction word and the two 64-bit source operand values that the register file has already read. It decodes the primary opcode and, where needed, the secondary fields. It then computes a redirect target, a taken indication that marks the following instruction as a delay slot, and a write to the link register for the calling variants.

There are three kinds of transfer. Absolute jumps stay inside the current 256 MB region of the address space. Register-indirect jumps take their address from an operand. Conditional branches are PC-relative and test either the sign of the first operand or the equality of both operands, always over the full 64 bits. All results are registered, so they appear one clock after the inputs are presented. A synchronous reset clears every valid and enable flag.

Top module: `bju_top`

## Requirements
- R1: Opcode 2 (plain) and opcode 3 (calling) are absolute jumps and are always taken. The target keeps the upper 4 bits of the PC and fills the lower 28 bits with instruction bits 25..0 followed by two zero bits.
- R2: Opcode 0 with function field (bits 5..0) equal to 8 (plain) or 9 (calling) is a register-indirect jump and is always taken. Its target is the low 32 bits of the first operand.
- R3: Opcode 3 and opcode 0 with function 9 always write the link register. The index is 31 and the data is PC+4 (modulo 2^32), sign-extended from bit 31 to 64 bits.
- R4: For a taken conditional branch, the target is the PC plus the 16-bit immediate (bits 15..0), sign-extended and shifted left by two, with the sum taken modulo 2^32.
- R5: The sign tests read the first operand as a signed 64-bit number. Opcode 1 with bits 20..16 equal to 0 or 16 branches when it is below zero. Opcode 1 with those bits equal to 1 or 17 branches when it is zero or above. Opcode 6 branches when it is zero or below. Opcode 7 branches when it is above zero.
- R6: Opcode 4 branches when the two 64-bit operands are equal in every bit. Opcode 5 branches when they differ in any bit.
- R7: The next-PC valid flag and the delay-slot flag are both set for every jump. For a conditional branch they are set only when its condition holds.
- R8: Any other instruction clears next-PC valid, delay-slot and link enable. This covers the other opcodes, opcode 0 with other function codes, and opcode 1 with other values in bits 20..16.
- R9: Outputs change only on a rising clock edge and reflect the inputs sampled at that edge. While reset is high at an edge, next-PC valid, delay-slot and link enable are cleared.
- R10: Opcode 1 with bits 20..16 equal to 16 or 17 writes the link register (as in R3) only when the branch is taken. No other conditional branch ever writes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_i | input | 32 | Address of the instruction being resolved |
| insn_i | input | 32 | Instruction word |
| src_a_i | input | 64 | First source operand value |
| src_b_i | input | 64 | Second source operand value |
| npc_vld_o | output | 1 | Redirect target is valid (transfer taken) |
| npc_o | output | 32 | Redirect target address |
| dslot_o | output | 1 | Next instruction executes as a delay slot |
| lnk_we_o | output | 1 | Link register write enable |
| lnk_idx_o | output | 5 | Link register index |
| lnk_data_o | output | 64 | Link register write data |

## Verification
The assertions assume that reset is high on the first clock edge, that every input is a known value on each rising edge, and that a fresh instruction may arrive on every cycle with no handshake. The stimulus therefore holds reset for several cycles at start-up and changes inputs only on falling edges. It also drives defined values on every cycle, including idle ones, and presents one instruction per cycle. Operands are drawn from the sign and equality boundaries (zero, all ones, the most negative and most positive 64-bit values, and one) as well as random values. PCs that wrap at the top of the address space or cross bit 31 on the link increment are included.

// File: rtl/bju_pkg.sv
package bju_pkg;

  localparam int OPC_W = 6;

  localparam logic [OPC_W-1:0] OPC_SPECIAL = 6'd0;
  localparam logic [OPC_W-1:0] OPC_SIGNTST = 6'd1;
  localparam logic [OPC_W-1:0] OPC_JABS    = 6'd2;
  localparam logic [OPC_W-1:0] OPC_JABSL   = 6'd3;
  localparam logic [OPC_W-1:0] OPC_BRZEQ   = 6'd4;
  localparam logic [OPC_W-1:0] OPC_BRZNE   = 6'd5;
  localparam logic [OPC_W-1:0] OPC_BRLEZ   = 6'd6;
  localparam logic [OPC_W-1:0] OPC_BRGTZ   = 6'd7;

  localparam logic [5:0] FN_JREG  = 6'd8;
  localparam logic [5:0] FN_JREGL = 6'd9;

  localparam logic [4:0] ST_LTZ  = 5'd0;
  localparam logic [4:0] ST_GEZ  = 5'd1;
  localparam logic [4:0] ST_LTZL = 5'd16;
  localparam logic [4:0] ST_GEZL = 5'd17;

  typedef enum logic [3:0] {
    CF_NONE,
    CF_JABS,
    CF_JREG,
    CF_BEQ,
    CF_BNE,
    CF_BLEZ,
    CF_BGTZ,
    CF_BLTZ,
    CF_BGEZ
  } cf_kind_e;

  typedef struct packed {
    cf_kind_e kind;
    logic     link;
  } cf_dec_t;

endpackage

// File: rtl/bju_decode.sv
module bju_decode
  import bju_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  input  logic [4:0]       sel_i,
  input  logic [5:0]       fn_i,
  output cf_dec_t          dec_o
);

  always_comb begin
    dec_o.kind = CF_NONE;
    dec_o.link = 1'b0;
    unique case (opc_i)
      OPC_JABS:  dec_o.kind = CF_JABS;
      OPC_JABSL: begin
        dec_o.kind = CF_JABS;
        dec_o.link = 1'b1;
      end
      OPC_SPECIAL: begin
        if (fn_i == FN_JREG || fn_i == FN_JREGL) begin
          dec_o.kind = CF_JREG;
          dec_o.link = (fn_i == FN_JREGL);
        end
      end
      OPC_SIGNTST: begin
        unique case (sel_i)
          ST_LTZ:  dec_o.kind = CF_BLTZ;
          ST_GEZ:  dec_o.kind = CF_BGEZ;
          ST_LTZL: begin
            dec_o.kind = CF_BLTZ;
            dec_o.link = 1'b1;
          end
          ST_GEZL: begin
            dec_o.kind = CF_BGEZ;
            dec_o.link = 1'b1;
          end
          default: dec_o.kind = CF_NONE;
        endcase
      end
      OPC_BRZEQ: dec_o.kind = CF_BEQ;
      OPC_BRZNE: dec_o.kind = CF_BNE;
      OPC_BRLEZ: dec_o.kind = CF_BLEZ;
      OPC_BRGTZ: dec_o.kind = CF_BGTZ;
      default:   dec_o.kind = CF_NONE;
    endcase
  end

endmodule

// File: rtl/bju_cond.sv
module bju_cond
  import bju_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  cf_kind_e          kind_i,
  input  logic [XLEN-1:0]   a_i,
  input  logic [XLEN-1:0]   b_i,
  output logic              taken_o
);

  logic neg, zero, same;

  assign neg  = a_i[XLEN-1];
  assign zero = (a_i == '0);
  assign same = (a_i == b_i);

  always_comb begin
    unique case (kind_i)
      CF_JABS, CF_JREG: taken_o = 1'b1;
      CF_BEQ:           taken_o = same;
      CF_BNE:           taken_o = !same;
      CF_BLEZ:          taken_o = neg || zero;
      CF_BGTZ:          taken_o = !neg && !zero;
      CF_BLTZ:          taken_o = neg;
      CF_BGEZ:          taken_o = !neg;
      default:          taken_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/bju_target.sv
module bju_target
  import bju_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int XLEN  = 64,
  parameter int IMM_W = 16,
  parameter int TGT_W = 26
) (
  input  cf_kind_e          kind_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [TGT_W-1:0]  field_i,
  input  logic [PC_W-1:0]   reg_i,
  output logic [PC_W-1:0]   tgt_o,
  output logic [XLEN-1:0]   link_o
);

  localparam int REGION_W = PC_W - TGT_W - 2;
  localparam int EXT_W    = PC_W - IMM_W - 2;

  logic [IMM_W-1:0] imm;
  logic [PC_W-1:0]  region_tgt;
  logic [PC_W-1:0]  rel_tgt;
  logic [PC_W-1:0]  ret_addr;

  assign imm        = field_i[IMM_W-1:0];
  assign region_tgt = {pc_i[PC_W-1 -: REGION_W], field_i, 2'b00};
  assign rel_tgt    = pc_i + {{EXT_W{imm[IMM_W-1]}}, imm, 2'b00};
  assign ret_addr   = pc_i + PC_W'(4);

  generate
    if (XLEN > PC_W) begin : g_sext
      assign link_o = {{(XLEN-PC_W){ret_addr[PC_W-1]}}, ret_addr};
    end else begin : g_trunc
      assign link_o = XLEN'(ret_addr);
    end
  endgenerate

  always_comb begin
    unique case (kind_i)
      CF_JABS: tgt_o = region_tgt;
      CF_JREG: tgt_o = reg_i;
      default: tgt_o = rel_tgt;
    endcase
  end

endmodule

// File: rtl/bju_top.sv
module bju_top
  import bju_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int XLEN     = 64,
  parameter int RIDX_W   = 5,
  parameter int LINK_REG = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [31:0]       insn_i,
  input  logic [XLEN-1:0]   src_a_i,
  input  logic [XLEN-1:0]   src_b_i,
  output logic              npc_vld_o,
  output logic [PC_W-1:0]   npc_o,
  output logic              dslot_o,
  output logic              lnk_we_o,
  output logic [RIDX_W-1:0] lnk_idx_o,
  output logic [XLEN-1:0]   lnk_data_o
);

  localparam int TGT_W = 26;
  localparam int IMM_W = 16;

  cf_dec_t         dec;
  logic            taken;
  logic [PC_W-1:0] tgt;
  logic [XLEN-1:0] link_val;

  bju_decode u_dec (
    .opc_i (insn_i[31:26]),
    .sel_i (insn_i[20:16]),
    .fn_i  (insn_i[5:0]),
    .dec_o (dec)
  );

  bju_cond #(.XLEN(XLEN)) u_cond (
    .kind_i  (dec.kind),
    .a_i     (src_a_i),
    .b_i     (src_b_i),
    .taken_o (taken)
  );

  bju_target #(
    .PC_W (PC_W), .XLEN (XLEN), .IMM_W (IMM_W), .TGT_W (TGT_W)
  ) u_tgt (
    .kind_i  (dec.kind),
    .pc_i    (pc_i),
    .field_i (insn_i[TGT_W-1:0]),
    .reg_i   (src_a_i[PC_W-1:0]),
    .tgt_o   (tgt),
    .link_o  (link_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      npc_vld_o  <= 1'b0;
      dslot_o    <= 1'b0;
      lnk_we_o   <= 1'b0;
      npc_o      <= '0;
      lnk_idx_o  <= '0;
      lnk_data_o <= '0;
    end else begin
      npc_vld_o  <= taken;
      dslot_o    <= taken;
      lnk_we_o   <= taken && dec.link;
      npc_o      <= tgt;
      lnk_idx_o  <= RIDX_W'(LINK_REG);
      lnk_data_o <= link_val;
    end
  end

  // R8
  dec_kind_sane_chk: assert property (@(posedge clk) disable iff (rst)
    (dec.kind == CF_NONE) |-> (!taken && !(taken && dec.link)));

  // R1
  abs_region_kept_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && ($past(insn_i[31:26]) == OPC_JABS || $past(insn_i[31:26]) == OPC_JABSL))
    |-> (npc_vld_o && npc_o[PC_W-1 -: 4] == $past(pc_i[PC_W-1 -: 4])));

  // R3
  link_shape_chk: assert property (@(posedge clk) disable iff (rst)
    lnk_we_o |-> (lnk_idx_o == RIDX_W'(LINK_REG) &&
                  (&lnk_data_o[XLEN-1:PC_W-1] || ~|lnk_data_o[XLEN-1:PC_W-1])));

  // R10
  link_needs_taken_chk: assert property (@(posedge clk) disable iff (rst)
    lnk_we_o |-> (dslot_o && npc_vld_o));

  // R7
  slot_matches_valid_chk: assert property (@(posedge clk) disable iff (rst)
    dslot_o == npc_vld_o);

  // R9
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!npc_vld_o && !dslot_o && !lnk_we_o));

endmodule

// File: tb/tb_bju_top.sv
module tb_bju_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pc  = '0;
  logic [31:0] insn = '0;
  logic [63:0] a = '0;
  logic [63:0] b = '0;
  logic        npc_vld, dslot, lnk_we;
  logic [31:0] npc;
  logic [4:0]  lnk_idx;
  logic [63:0] lnk_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic        vld;
    logic [31:0] npc;
    logic        we;
    logic [63:0] data;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  bju_top dut (
    .clk (clk), .rst (rst), .pc_i (pc), .insn_i (insn),
    .src_a_i (a), .src_b_i (b),
    .npc_vld_o (npc_vld), .npc_o (npc), .dslot_o (dslot),
    .lnk_we_o (lnk_we), .lnk_idx_o (lnk_idx), .lnk_data_o (lnk_data)
  );

  function automatic exp_t model(logic [31:0] p, logic [31:0] w, logic [63:0] x, logic [63:0] y);
    exp_t e;
    logic take, lnk;
    logic [31:0] ret, rel;
    take = 1'b0;
    lnk  = 1'b0;
    ret  = p + 32'd4;
    rel  = p + {{14{w[15]}}, w[15:0], 2'b00};
    e.npc = rel;
    case (w[31:26])
      6'd2, 6'd3: begin take = 1; lnk = (w[31:26] == 6'd3); e.npc = {p[31:28], w[25:0], 2'b00}; end
      6'd0: if (w[5:0] == 6'd8 || w[5:0] == 6'd9) begin
              take = 1; lnk = (w[5:0] == 6'd9); e.npc = x[31:0];
            end
      6'd1: case (w[20:16])
              5'd0, 5'd16: begin take = ($signed(x) < 0);  lnk = w[20]; end
              5'd1, 5'd17: begin take = ($signed(x) >= 0); lnk = w[20]; end
              default: ;
            endcase
      6'd4: take = (x == y);
      6'd5: take = (x != y);
      6'd6: take = ($signed(x) <= 0);
      6'd7: take = ($signed(x) > 0);
      default: ;
    endcase
    e.vld  = take;
    e.we   = take && lnk;
    e.data = {{32{ret[31]}}, ret};
    return e;
  endfunction

  task automatic drive(logic [31:0] p, logic [31:0] w, logic [63:0] x, logic [63:0] y, string tag);
    @(negedge clk);
    pc = p; insn = w; a = x; b = y;
    exp_q.push_back(model(p, w, x, y));
    tag_q.push_back(tag);
  endtask

  // scoreboard monitor: results of the previous negedge's inputs are visible 1ns after the edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t  e;
      string t;
      bit    bad;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      bad = (npc_vld !== e.vld) || (dslot !== e.vld) || (lnk_we !== e.we) ||
            (e.vld && npc !== e.npc) ||
            (e.we && (lnk_idx !== 5'd31 || lnk_data !== e.data));
      checks++;
      if (bad) begin
        errors++;
        $display("FAIL %s: got vld=%0b ds=%0b npc=%h we=%0b idx=%0d data=%h exp vld=%0b npc=%h we=%0b idx=31 data=%h",
                 t, npc_vld, dslot, npc, lnk_we, lnk_idx, lnk_data, e.vld, e.npc, e.we, e.data);
      end
    end
  end

  task automatic check_cleared(string tag);
    checks++;
    if (npc_vld !== 1'b0 || dslot !== 1'b0 || lnk_we !== 1'b0) begin
      errors++;
      $display("FAIL %s: got vld=%0b ds=%0b we=%0b exp all 0", tag, npc_vld, dslot, lnk_we);
    end
  endtask

  function automatic logic [63:0] pick(int k);
    case (k % 6)
      0: return 64'd0;
      1: return '1;
      2: return 64'h8000_0000_0000_0000;
      3: return 64'h7FFF_FFFF_FFFF_FFFF;
      4: return 64'd1;
      default: return {$urandom(), $urandom()};
    endcase
  endfunction

  function automatic logic [31:0] itype(logic [5:0] op, logic [4:0] sel, logic [15:0] imm);
    return {op, 5'($urandom()), sel, imm};
  endfunction

  function automatic logic [31:0] rtype(logic [5:0] fn);
    return {6'd0, 5'($urandom()), 15'($urandom()), fn};
  endfunction

  initial begin
    // R9: reset state
    repeat (3) @(posedge clk);
    #1 check_cleared("R9 reset");
    @(negedge clk) rst = 1'b0;

    // R1 absolute jumps, R3 calling variant
    for (int i = 0; i < 20; i++) begin
      logic [31:0] w;
      w = {6'd2, 26'($urandom())};
      drive($urandom(), w, pick(i), pick(i + 1), "R1");
      w = {6'd3, 26'($urandom())};
      drive($urandom(), w, pick(i), pick(i + 2), "R3");
    end
    drive(32'hFFFF_FFFC, {6'd3, 26'h3FF_FFFF}, '0, '0, "R3");
    drive(32'h7FFF_FFFC, {6'd3, 26'h0}, '0, '0, "R3");

    // R2 register-indirect jumps
    for (int i = 0; i < 20; i++) begin
      drive($urandom(), rtype(6'd8), pick(i), pick(i + 3), "R2");
      drive($urandom(), rtype(6'd9), pick(i), pick(i + 3), "R3");
    end

    // R6 equality over 64 bits, including high-half-only differences
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++) begin
        drive($urandom(), itype(6'd4, 5'($urandom()), 16'($urandom())), pick(i), pick(j), "R6");
        drive($urandom(), itype(6'd5, 5'($urandom()), 16'($urandom())), pick(i), pick(j), "R6");
      end
    drive(32'h1000, itype(6'd4, 5'd0, 16'h0010), 64'h1_0000_0005, 64'h2_0000_0005, "R6");
    drive(32'h1000, itype(6'd5, 5'd0, 16'h0010), 64'h1_0000_0005, 64'h2_0000_0005, "R6");

    // R5 sign tests, R10 conditional link
    for (int i = 0; i < 24; i++) begin
      drive($urandom(), itype(6'd1, 5'd0,  16'($urandom())), pick(i), pick(i), "R5");
      drive($urandom(), itype(6'd1, 5'd1,  16'($urandom())), pick(i), pick(i), "R5");
      drive($urandom(), itype(6'd1, 5'd16, 16'($urandom())), pick(i), pick(i), "R10");
      drive($urandom(), itype(6'd1, 5'd17, 16'($urandom())), pick(i), pick(i), "R10");
      drive($urandom(), itype(6'd6, 5'($urandom()), 16'($urandom())), pick(i), pick(i + 1), "R5");
      drive($urandom(), itype(6'd7, 5'($urandom()), 16'($urandom())), pick(i), pick(i + 1), "R5");
    end
    drive(32'h0000_0100, itype(6'd1, 5'd16, 16'h0001), 64'h0000_0001_0000_0000, '0, "R5");

    // R4 offset extremes and wraparound
    drive(32'h0000_0010, itype(6'd4, 5'd0, 16'h8000), '0, '0, "R4");
    drive(32'hFFFF_FFF0, itype(6'd4, 5'd0, 16'h7FFF), '0, '0, "R4");
    drive(32'h8000_0000, itype(6'd7, 5'd0, 16'hFFFF), 64'd5, '0, "R4");

    // R8 non-control-flow words
    for (int i = 0; i < 30; i++) begin
      logic [5:0] op;
      op = 6'(8 + ($urandom() % 56));
      drive($urandom(), {op, 26'($urandom())}, pick(i), pick(i), "R8");
    end
    drive($urandom(), rtype(6'd0),  '1, '1, "R8");
    drive($urandom(), rtype(6'd10), '1, '1, "R8");
    drive($urandom(), itype(6'd1, 5'd2,  16'h4), '1, '1, "R8");
    drive($urandom(), itype(6'd1, 5'd18, 16'h4), '0, '0, "R8");

    // R9: reset during a taken jump clears flags
    wait (exp_q.size() == 0);
    @(negedge clk);
    rst = 1'b1; insn = {6'd3, 26'h123}; pc = 32'h4000_0000;
    @(posedge clk);
    #1 check_cleared("R9 mid-run reset");
    @(negedge clk) rst = 1'b0;
    drive(32'h4000_0000, {6'd3, 26'h123}, '0, '0, "R9");
    drive(32'h4000_0000, rtype(6'd0), '0, '0, "R9");
    wait (exp_q.size() == 0);
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule